// File: doc/BRIEF.md
# Frame queue with watermark and age interrupts

This block holds frame descriptors in order between a producer and a consumer. The producer places a 64-bit descriptor through a valid/ready enqueue port. The consumer takes the oldest descriptor through a valid/ready dequeue port. Each stored entry carries the value of a free-running cycle counter taken at the moment it was accepted. From that value the block knows how long the frame at the head has been waiting. The frame at the head is always the oldest one, so only its timestamp is compared.

The block raises a single interrupt when either of two conditions holds:
- the number of queued frames is larger than a programmed fill limit;
- the head frame has waited more cycles than a programmed wait limit.

The interrupt is sticky. It clears only when software acknowledges it, and after that it re-arms. As a result the consumer is notified about a batch or a stale frame, not about every arrival. Both limits can be written at any time through a plain write strobe.

Backpressure rules:
- The enqueue side is refused while the queue is full. A descriptor offered while `enq_ready` is low is dropped, and the producer must hold it until `enq_ready` is high.
- The dequeue side presents the head whenever `deq_valid` is high. It advances on a cycle with both `deq_valid` and `deq_ready` high.
- Neither ready signal depends combinationally on the other side.

Top module: `frame_queue_irq`

## Requirements
- R1: After reset `enq_ready`=1, `deq_valid`=0, `deq_desc`=0 and `irq`=0. The fill limit resets to 32 and the wait limit resets to 65535, so neither condition can fire until software writes a limit.
- R2: Descriptors leave in exactly the order they were accepted. While `deq_valid` is 1, `deq_desc` shows the head entry, and it stays unchanged until the head is taken.
- R3: Once 32 entries are held, `enq_ready` is 0, even in a cycle where the consumer takes an entry. A descriptor offered then is dropped and does not appear later.
- R4: An empty queue shows `deq_valid`=0 and `deq_desc`=0. Asserting `deq_ready` while the queue is empty changes nothing.
- R5: An accepted enqueue and an accepted dequeue in the same cycle leave the stored count unchanged and keep the order of the entries.
- R6: If at a clock edge the stored count is larger than the fill limit and `irq` is 0, then `irq` is 1 after that edge.
- R7: The age of the head is the number of clock edges since the edge that accepted it. If at an edge that age is larger than the wait limit and `irq` is 0, then `irq` is 1 after that edge.
- R8: Once set, `irq` stays 1 until an edge at which `irq_ack` is 1. After that edge `irq` is 0.
- R9: After an acknowledge, both conditions are evaluated again on the next edge. If either still holds, `irq` returns to 1 one cycle after it fell.
- R10: A cycle with `cfg_we`=1 writes one limit, and the new value takes effect from the next edge.
  - With `cfg_sel`=0 it writes the fill limit from `cfg_wdata[5:0]`.
  - With `cfg_sel`=1 it writes the 16-bit wait limit from `cfg_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Producer offers a descriptor |
| enq_ready | output | 1 | Queue can accept (not full) |
| enq_desc | input | 64 | Descriptor to enqueue |
| deq_valid | output | 1 | Head descriptor present (queue not empty) |
| deq_ready | input | 1 | Consumer takes the head |
| deq_desc | output | 64 | Head descriptor, zero when empty |
| cfg_we | input | 1 | Limit write strobe |
| cfg_sel | input | 1 | 0 selects fill limit, 1 selects wait limit |
| cfg_wdata | input | 16 | Limit value |
| irq | output | 1 | Sticky interrupt |
| irq_ack | input | 1 | Acknowledge, clears the interrupt |

## Verification
The acknowledge and the condition check can fall in the same cycle. The bench sends `irq_ack` while the count is still above the fill limit, and also while a stale head is still waiting. It then expects `irq` to drop for exactly one cycle and rise again. Enqueue and dequeue also meet in one cycle, including at the full boundary, where the push must still be refused. A cycle-level reference model in the bench predicts the count, the order, the timestamps and the interrupt state. Every cycle is judged against that model, in directed cases and in randomized traffic with random limit writes and acknowledges.

// File: rtl/fq_pkg.sv
package fq_pkg;
  parameter int DESC_W = 64;
  parameter int TS_W   = 16;

  typedef struct packed {
    logic [DESC_W-1:0] desc;
    logic [TS_W-1:0]   ts;
  } fq_entry_t;

  typedef enum logic {
    CFG_FILL_LIMIT = 1'b0,
    CFG_WAIT_LIMIT = 1'b1
  } fq_cfg_sel_e;
endpackage

// File: rtl/fq_timebase.sv
module fq_timebase #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] now
);
  always_ff @(posedge clk) begin
    if (!rst_n) now <= '0;
    else        now <= now + 1'b1;
  end

  a_r7_time_advances: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> now == $past(now) + 1'b1);
endmodule

// File: rtl/fq_store.sv
module fq_store
  import fq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  output logic             push_ready,
  input  fq_entry_t        push_entry,
  output logic             head_valid,
  input  logic             pop_ready,
  output fq_entry_t        head_entry,
  output logic [CNT_W-1:0] fill
);
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] fill_q;
  fq_entry_t        slot [DEPTH];
  logic             push_fire, pop_fire;

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign push_ready = (fill_q != CNT_W'(DEPTH));
  assign head_valid = (fill_q != '0);
  assign push_fire  = push_valid && push_ready;
  assign pop_fire   = pop_ready && head_valid;
  assign head_entry = slot[rd_ptr];
  assign fill       = fill_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_fire && wr_ptr == PTR_W'(i)) slot[i] <= push_entry;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill_q <= '0;
    end else begin
      if (push_fire) wr_ptr <= step_ptr(wr_ptr);
      if (pop_fire)  rd_ptr <= step_ptr(rd_ptr);
      case ({push_fire, pop_fire})
        2'b10:   fill_q <= fill_q + 1'b1;
        2'b01:   fill_q <= fill_q - 1'b1;
        default: fill_q <= fill_q;
      endcase
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CNT_W'(DEPTH));
  a_r2_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    head_valid && !pop_ready |=> head_valid && $stable(head_entry));
  a_r5_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fill_q == $past(fill_q)) || (fill_q == $past(fill_q) + 1'b1)
             || (fill_q + 1'b1 == $past(fill_q)));
endmodule

// File: rtl/fq_cfg_regs.sv
module fq_cfg_regs
  import fq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int TS_W  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [TS_W-1:0]  cfg_wdata,
  output logic [CNT_W-1:0] fill_limit,
  output logic [TS_W-1:0]  wait_limit
);
  fq_cfg_sel_e sel;
  assign sel = fq_cfg_sel_e'(cfg_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_limit <= CNT_W'(DEPTH);
      wait_limit <= '1;
    end else if (cfg_we) begin
      if (sel == CFG_FILL_LIMIT) fill_limit <= cfg_wdata[CNT_W-1:0];
      else                       wait_limit <= cfg_wdata;
    end
  end

  a_r10_hold_unwritten: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(fill_limit) && $stable(wait_limit));
endmodule

// File: rtl/fq_irq_ctrl.sv
module fq_irq_ctrl #(
  parameter int CNT_W = 6,
  parameter int TS_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fill,
  input  logic [CNT_W-1:0] fill_limit,
  input  logic             head_valid,
  input  logic [TS_W-1:0]  head_ts,
  input  logic [TS_W-1:0]  now,
  input  logic [TS_W-1:0]  wait_limit,
  input  logic             irq_ack,
  output logic             irq
);
  logic [TS_W-1:0] head_age;
  logic            fill_hit, age_hit, fire;

  assign head_age = now - head_ts;
  assign fill_hit = fill > fill_limit;
  assign age_hit  = head_valid && (head_age > wait_limit);
  assign fire     = fill_hit || age_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)   irq <= 1'b0;
    else if (irq) irq <= !irq_ack;
    else          irq <= fire;
  end

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_ack |=> irq);
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq && irq_ack |=> !irq);
  a_r6_fill_fires: assert property (@(posedge clk) disable iff (!rst_n)
    !irq && (fill > fill_limit) |=> irq);
  a_r7_age_fires: assert property (@(posedge clk) disable iff (!rst_n)
    !irq && head_valid && ((now - head_ts) > wait_limit) |=> irq);
endmodule

// File: rtl/frame_queue_irq.sv
module frame_queue_irq
  import fq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_valid,
  output logic              enq_ready,
  input  logic [DESC_W-1:0] enq_desc,
  output logic              deq_valid,
  input  logic              deq_ready,
  output logic [DESC_W-1:0] deq_desc,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [TS_W-1:0]   cfg_wdata,
  output logic              irq,
  input  logic              irq_ack
);
  logic [TS_W-1:0]  now;
  logic [CNT_W-1:0] fill, fill_limit;
  logic [TS_W-1:0]  wait_limit;
  fq_entry_t        in_entry, head_entry;

  assign in_entry.desc = enq_desc;
  assign in_entry.ts   = now;

  fq_timebase #(.TS_W(TS_W)) u_time (
    .clk(clk), .rst_n(rst_n), .now(now)
  );

  fq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push_valid(enq_valid), .push_ready(enq_ready), .push_entry(in_entry),
    .head_valid(deq_valid), .pop_ready(deq_ready), .head_entry(head_entry),
    .fill(fill)
  );

  fq_cfg_regs #(.DEPTH(DEPTH), .TS_W(TS_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .fill_limit(fill_limit), .wait_limit(wait_limit)
  );

  fq_irq_ctrl #(.CNT_W(CNT_W), .TS_W(TS_W)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .fill(fill), .fill_limit(fill_limit),
    .head_valid(deq_valid), .head_ts(head_entry.ts),
    .now(now), .wait_limit(wait_limit),
    .irq_ack(irq_ack), .irq(irq)
  );

  assign deq_desc = deq_valid ? head_entry.desc : '0;

  a_r3_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    !enq_ready && !deq_ready |=> !enq_ready);
  a_r4_empty_stays: assert property (@(posedge clk) disable iff (!rst_n)
    !deq_valid && !enq_valid |=> !deq_valid);
endmodule

// File: tb/sim_frame_queue_irq.sv
`timescale 1ns/1ps
module sim_frame_queue_irq;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enq_valid, deq_ready, cfg_we, cfg_sel, irq_ack;
  logic [63:0] enq_desc;
  logic [15:0] cfg_wdata;
  logic        enq_ready, deq_valid, irq;
  logic [63:0] deq_desc;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference model state
  logic [63:0] q_d[$];
  logic [15:0] q_t[$];
  logic [15:0] m_now;
  logic [5:0]  m_thr;
  logic [15:0] m_lim;
  logic        m_irq;

  always #2.5 clk = ~clk;

  frame_queue_irq u0 (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_desc(enq_desc),
    .deq_valid(deq_valid), .deq_ready(deq_ready), .deq_desc(deq_desc),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .irq(irq), .irq_ack(irq_ack)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic model_fire();
    logic [15:0] age;
    if (q_d.size() > int'(m_thr)) return 1'b1;
    if (q_d.size() == 0) return 1'b0;
    age = m_now - q_t[0];
    return age > m_lim;
  endfunction

  // one cycle: check outputs, drive inputs, advance the model, cross the edge
  task automatic step(input string tag, input logic ev, input logic [63:0] ed,
                      input logic dr, input logic ack, input logic cwe,
                      input logic csel, input logic [15:0] cwd);
    logic push, pop, nirq;
    chk(tag, "enq_ready", 64'(enq_ready), 64'(q_d.size() < DEPTH));
    chk(tag, "deq_valid", 64'(deq_valid), 64'(q_d.size() > 0));
    chk(tag, "deq_desc", deq_desc, (q_d.size() > 0) ? q_d[0] : 64'd0);
    chk(tag, "irq", 64'(irq), 64'(m_irq));
    enq_valid = ev; enq_desc = ed; deq_ready = dr; irq_ack = ack;
    cfg_we = cwe; cfg_sel = csel; cfg_wdata = cwd;
    nirq = m_irq ? !ack : model_fire();
    push = ev && (q_d.size() < DEPTH);
    pop  = dr && (q_d.size() > 0);
    if (pop) begin void'(q_d.pop_front()); void'(q_t.pop_front()); end
    if (push) begin q_d.push_back(ed); q_t.push_back(m_now); end
    if (cwe) begin
      if (csel) m_lim = cwd;
      else      m_thr = cwd[5:0];
    end
    m_irq = nirq;
    m_now = m_now + 16'd1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input string tag, input int n, input logic ack);
    for (int i = 0; i < n; i++) step(tag, 0, 64'd0, 0, ack, 0, 0, 16'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; enq_valid = 0; enq_desc = '0; deq_ready = 0;
    cfg_we = 0; cfg_sel = 0; cfg_wdata = '0; irq_ack = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    m_now = 16'd0; m_thr = 6'd32; m_lim = 16'hFFFF; m_irq = 1'b0;

    // R1: reset state
    idle("R1", 2, 0);

    // R4: dequeue attempts on empty queue
    for (int i = 0; i < 3; i++) step("R4", 0, 64'd0, 1, 0, 0, 0, 16'd0);

    // R3: fill beyond capacity, extra offers dropped
    for (int i = 0; i < 34; i++) step("R3", 1, 64'hA500_0000_0000_0000 + 64'(i), 0, 0, 0, 0, 16'd0);
    step("R3", 1, 64'hDEAD, 1, 0, 0, 0, 16'd0);   // full: push refused while pop taken
    // R2: drain and check order
    for (int i = 0; i < 34; i++) step("R2", 0, 64'd0, 1, 0, 0, 0, 16'd0);

    // R10 + R6: fill limit 3, then 4 entries
    step("R10", 0, 64'd0, 0, 0, 1, 0, 16'd3);
    for (int i = 0; i < 4; i++) step("R6", 1, 64'h600 + 64'(i), 0, 0, 0, 0, 16'd0);
    idle("R8", 5, 0);
    step("R8", 0, 64'd0, 0, 1, 0, 0, 16'd0);      // ack while condition holds
    idle("R9", 3, 0);                              // must re-assert
    for (int i = 0; i < 4; i++) step("R9", 0, 64'd0, 1, 1, 0, 0, 16'd0);
    idle("R9", 3, 1);

    // R7: age limit 10 with fill limit disabled
    step("R10", 0, 64'd0, 0, 0, 1, 0, 16'd32);
    step("R10", 0, 64'd0, 0, 0, 1, 1, 16'd10);
    step("R7", 1, 64'h7777, 0, 0, 0, 0, 16'd0);
    idle("R7", 14, 0);
    step("R7", 0, 64'd0, 1, 1, 0, 0, 16'd0);
    idle("R7", 4, 0);

    // R5: simultaneous push and pop with two held
    step("R5", 1, 64'h51, 0, 0, 0, 0, 16'd0);
    step("R5", 1, 64'h52, 0, 0, 0, 0, 16'd0);
    step("R5", 1, 64'h53, 1, 0, 0, 0, 16'd0);
    idle("R5", 2, 1);
    for (int i = 0; i < 3; i++) step("R5", 0, 64'd0, 1, 1, 0, 0, 16'd0);

    // randomized traffic in three load patterns (R5, R6, R7, R9, R10)
    for (int seg = 0; seg < 3; seg++) begin
      int pin, pout;
      pin  = (seg == 0) ? 55 : (seg == 1) ? 80 : 30;
      pout = (seg == 0) ? 45 : (seg == 1) ? 20 : 70;
      for (int i = 0; i < 1500; i++) begin
        logic ev, dr, ack, cwe, csel;
        logic [15:0] cwd;
        ev   = ($urandom % 100) < pin;
        dr   = ($urandom % 100) < pout;
        ack  = ($urandom % 100) < 15;
        cwe  = ($urandom % 100) < 3;
        csel = $urandom % 2;
        cwd  = csel ? 16'($urandom % 60) : 16'($urandom % 40);
        step("R5", ev, {$urandom, $urandom}, dr, ack, cwe, csel, cwd);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule